// File: doc/BRIEF.md
# Split Instruction/Data Page Mapper

This block translates 16-bit virtual addresses into physical addresses using a page table that lives entirely in on-chip registers. No part of the table is fetched from memory. The virtual space is cut into eight pages of 8 KB each. The top three address bits pick a page and the low thirteen bits are the byte offset. There are two banks of eight translation entries. An instruction fetch is looked up only in the instruction bank, and a load or store only in the data bank. Instruction space and data space are therefore fully separate, and a data access can never reach an instruction mapping.

Each entry holds a physical frame number, a valid flag and a write-permit flag. Privileged software sets single entries through a configuration write port. On a context switch it starts a swap that loads all sixteen entries in a fixed order from an external source, one per clock cycle. Translation requests are held off while the swap runs.

Each accepted request produces one registered response, one cycle later. The response is either the physical address, which is the frame number placed above the untouched offset, or a fault that reports which bank and which page caused it.

Top module: `split_page_mapper`

## Requirements
- R1: After reset every entry in both banks is invalid, `rsp_valid` is 0 and `sw_busy` is 0, so any request made right after reset faults.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. On the next cycle `rsp_valid` is 1. If there is no fault, `rsp_paddr` equals the entry's frame number times 8192 plus `req_vaddr[12:0]`, and the page index is `req_vaddr[15:13]`.
- R3: With `req_ifetch`=1 the lookup uses the instruction bank. With `req_ifetch`=0 it uses the data bank. The same page index in the two banks gives independent results.
- R4: If the selected entry is invalid, the response has `rsp_fault`=1, `rsp_paddr`=0, `rsp_fault_bank` set to the bank (0 = instruction, 1 = data) and `rsp_fault_page` set to the page index. When there is no fault, both report fields read 0.
- R5: A data access with `req_write`=1 to a valid entry whose write-permit flag is 0 faults as in R4. A data read from the same entry translates normally. For an instruction fetch, `req_write` and the write-permit flag have no effect.
- R6: A configuration write (`cfg_we`=1, with `cfg_bank` 0 = instruction and 1 = data) replaces exactly the one selected entry. The change is seen by requests accepted from the next cycle on.
- R7: A `sw_start` pulse while idle raises `sw_busy` on the next cycle and holds it for exactly 16 cycles. During those cycles `sw_idx` steps through 0 to 15. Bit 3 of `sw_idx` selects the bank (0 = instruction), bits 2:0 select the page, and on each cycle the entry named by `sw_idx` is loaded from `sw_pfn`, `sw_valid` and `sw_wen`.
- R8: While `sw_busy` is 1, `req_ready` is 0, no request is accepted and no response appears.
- R9: While `sw_busy` is 1, configuration writes and further `sw_start` pulses are ignored. They neither change entries nor lengthen or restart the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Privileged single-entry write strobe |
| cfg_bank | input | 1 | Bank to write: 0 instruction, 1 data |
| cfg_page | input | 3 | Page index of entry to write |
| cfg_pfn | input | 5 | Frame number to store |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_wen | input | 1 | Write-permit flag to store |
| sw_start | input | 1 | Begin full-table swap |
| sw_busy | output | 1 | Swap in progress |
| sw_idx | output | 4 | Entry being loaded: bit 3 bank, bits 2:0 page |
| sw_pfn | input | 5 | Frame number for entry `sw_idx` |
| sw_valid | input | 1 | Valid flag for entry `sw_idx` |
| sw_wen | input | 1 | Write-permit flag for entry `sw_idx` |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_ifetch | input | 1 | 1 instruction fetch, 0 data access |
| req_write | input | 1 | Data store when 1 |
| req_vaddr | input | 16 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 18 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_bank | output | 1 | Faulting bank, 0 instruction, 1 data |
| rsp_fault_page | output | 3 | Faulting page index |

## Verification
The assertions assume that the swap source presents the entry for `sw_idx` in the same cycle, with no delay. The bench meets this by computing `sw_pfn`, `sw_valid` and `sw_wen` combinationally from `sw_idx`. The assertions also assume that requests respect `req_ready`. The bench tries a request during a swap only to observe that it is refused, and it drives every input half a cycle away from the active edge. Both banks, every page, reads and writes, and the lowest, highest and a middle offset are swept against mappings computed arithmetically. These mappings include invalid and read-only entries, before and after a swap.

// File: rtl/mapper_pkg.sv
// Shared definitions for the split page mapper.
// Assumes: bank encoding is visible on ports as a single bit.
package mapper_pkg;
    typedef enum logic {
        BANK_INSN = 1'b0,
        BANK_DATA = 1'b1
    } bank_e;
endpackage

// File: rtl/pte_bank.sv
// One bank of page translation registers.
// Holds frame number, valid and write-permit per page; one write port,
// one combinational read port. Assumes a single writer per cycle.
module pte_bank #(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 5,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [PFN_W-1:0] wpfn,
    input  logic             wvalid,
    input  logic             wwen,
    input  logic [IDX_W-1:0] ridx,
    output logic [PFN_W-1:0] rpfn,
    output logic             rvalid,
    output logic             rwen
);
    logic [PFN_W-1:0] pfn_q [ENTRIES];
    logic [ENTRIES-1:0] val_q;
    logic [ENTRIES-1:0] wen_q;

    // Entry storage: cleared to invalid on reset, updated on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            wen_q <= '0;
            for (int i = 0; i < ENTRIES; i++) pfn_q[i] <= '0;
        end else if (we) begin
            pfn_q[widx] <= wpfn;
            val_q[widx] <= wvalid;
            wen_q[widx] <= wwen;
        end
    end

    // Read port: selected entry fields.
    always_comb begin
        rpfn   = pfn_q[ridx];
        rvalid = val_q[ridx];
        rwen   = wen_q[ridx];
    end

    // R6
    entry_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (pfn_q[$past(widx)] == $past(wpfn)) && (val_q[$past(widx)] == $past(wvalid)));
endmodule

// File: rtl/swap_loader.sv
// Context-switch sequencer: walks all entries of both banks, one per cycle.
// Index order is instruction bank pages 0..N-1, then data bank pages 0..N-1.
// Assumes the external source supplies the entry for the shown index combinationally.
module swap_loader #(
    parameter int ENTRIES = 8,
    localparam int SW_W   = $clog2(ENTRIES) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic [SW_W-1:0] idx
);
    localparam logic [SW_W-1:0] LAST = SW_W'(2 * ENTRIES - 1);

    // Sequencer: start only when idle, step index, drop busy after last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end else if (idx == LAST) begin
            busy <= 1'b0;
            idx  <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end

    // R7
    swap_first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> idx == '0);
    // R7
    swap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> idx == SW_W'($past(idx) + 1'b1));
    // R9
    swap_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && $past(start)) |-> idx != '0);
endmodule

// File: rtl/xlate_stage.sv
// Permission check and physical address formation with a registered response.
// Assumes the entry inputs are already selected for the request's bank.
module xlate_stage #(
    parameter int PG_W   = 3,
    parameter int OFF_W  = 13,
    parameter int PFN_W  = 5,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             ifetch,
    input  logic             write,
    input  logic [PG_W-1:0]  page,
    input  logic [OFF_W-1:0] offset,
    input  logic [PFN_W-1:0] e_pfn,
    input  logic             e_valid,
    input  logic             e_wen,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             rsp_bank,
    output logic [PG_W-1:0]  rsp_page
);
    import mapper_pkg::*;

    logic  fault_d;
    bank_e bank_d;

    // Fault decision: invalid entry, or data store to a read-only entry.
    always_comb begin
        bank_d  = ifetch ? BANK_INSN : BANK_DATA;
        fault_d = !e_valid || (bank_d == BANK_DATA && write && !e_wen);
    end

    // Response register: address on success, bank/page report on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_bank  <= 1'b0;
            rsp_page  <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_fault <= accept && fault_d;
            rsp_paddr <= (accept && !fault_d) ? {e_pfn, offset} : '0;
            rsp_bank  <= (accept && fault_d) ? logic'(bank_d) : 1'b0;
            rsp_page  <= (accept && fault_d) ? page : '0;
        end
    end

    // R2
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(accept));
    // R4
    fault_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid && rsp_paddr == '0);
    // R5
    store_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && $past(write && !ifetch)) |-> $past(e_wen));
endmodule

// File: rtl/split_page_mapper.sv
// Top: split instruction/data page mapper with register-held page table.
// Two banks of translation entries, a privileged single-entry write port,
// a sequential full-table swap, and a one-cycle registered translation.
// Assumes requests honour req_ready and swap data tracks sw_idx in-cycle.
module split_page_mapper #(
    parameter int VA_W   = 16,
    parameter int PG_W   = 3,
    parameter int PFN_W  = 5,
    localparam int OFF_W = VA_W - PG_W,
    localparam int PA_W  = PFN_W + OFF_W,
    localparam int ENTRIES = 1 << PG_W,
    localparam int SW_W  = PG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_bank,
    input  logic [PG_W-1:0]  cfg_page,
    input  logic [PFN_W-1:0] cfg_pfn,
    input  logic             cfg_valid,
    input  logic             cfg_wen,
    input  logic             sw_start,
    output logic             sw_busy,
    output logic [SW_W-1:0]  sw_idx,
    input  logic [PFN_W-1:0] sw_pfn,
    input  logic             sw_valid,
    input  logic             sw_wen,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_ifetch,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             rsp_fault_bank,
    output logic [PG_W-1:0]  rsp_fault_page
);
    logic             wr_en;
    logic             wr_bank;
    logic [PG_W-1:0]  wr_page;
    logic [PFN_W-1:0] wr_pfn;
    logic             wr_valid;
    logic             wr_wen;
    logic [PG_W-1:0]  rd_page;
    logic [PFN_W-1:0] bk_pfn [2];
    logic [1:0]       bk_valid;
    logic [1:0]       bk_wen;
    logic             sel_bank;
    logic             accept;

    swap_loader #(.ENTRIES(ENTRIES)) u_loader (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sw_start),
        .busy  (sw_busy),
        .idx   (sw_idx)
    );

    // Write source select: swap sequencer owns the banks while busy.
    always_comb begin
        if (sw_busy) begin
            wr_en    = 1'b1;
            wr_bank  = sw_idx[SW_W-1];
            wr_page  = sw_idx[PG_W-1:0];
            wr_pfn   = sw_pfn;
            wr_valid = sw_valid;
            wr_wen   = sw_wen;
        end else begin
            wr_en    = cfg_we;
            wr_bank  = cfg_bank;
            wr_page  = cfg_page;
            wr_pfn   = cfg_pfn;
            wr_valid = cfg_valid;
            wr_wen   = cfg_wen;
        end
    end

    // Request handshake and bank selection.
    always_comb begin
        req_ready = !sw_busy;
        accept    = req_valid && !sw_busy;
        rd_page   = req_vaddr[VA_W-1 -: PG_W];
        sel_bank  = !req_ifetch;
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pte_bank #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en && (wr_bank == 1'(b))),
            .widx   (wr_page),
            .wpfn   (wr_pfn),
            .wvalid (wr_valid),
            .wwen   (wr_wen),
            .ridx   (rd_page),
            .rpfn   (bk_pfn[b]),
            .rvalid (bk_valid[b]),
            .rwen   (bk_wen[b])
        );
    end

    xlate_stage #(.PG_W(PG_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .ifetch    (req_ifetch),
        .write     (req_write),
        .page      (rd_page),
        .offset    (req_vaddr[OFF_W-1:0]),
        .e_pfn     (bk_pfn[sel_bank]),
        .e_valid   (bk_valid[sel_bank]),
        .e_wen     (bk_wen[sel_bank]),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault),
        .rsp_bank  (rsp_fault_bank),
        .rsp_page  (rsp_fault_page)
    );

    // R8
    no_rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_busy) |-> !rsp_valid);
endmodule

// File: tb/test_split_page_mapper.sv
module test_split_page_mapper;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_bank = 0, cfg_valid = 0, cfg_wen = 0;
    logic [2:0] cfg_page = '0;
    logic [4:0] cfg_pfn = '0;
    logic sw_start = 0, sw_busy;
    logic [3:0] sw_idx;
    logic [4:0] sw_pfn;
    logic sw_valid, sw_wen;
    logic req_valid = 0, req_ready, req_ifetch = 0, req_write = 0;
    logic [15:0] req_vaddr = '0;
    logic rsp_valid, rsp_fault, rsp_fault_bank;
    logic [17:0] rsp_paddr;
    logic [2:0] rsp_fault_page;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // model: index = bank*8 + page
    logic [4:0] m_pfn [16];
    logic       m_val [16];
    logic       m_wen [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    // swap source: pure function of the presented index
    assign sw_pfn   = 5'((int'(sw_idx) * 7 + 3) % 32);
    assign sw_valid = (sw_idx != 4'd9);
    assign sw_wen   = (sw_idx != 4'd12);

    split_page_mapper i_split_page_mapper (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_page(cfg_page),
        .cfg_pfn(cfg_pfn), .cfg_valid(cfg_valid), .cfg_wen(cfg_wen),
        .sw_start(sw_start), .sw_busy(sw_busy), .sw_idx(sw_idx),
        .sw_pfn(sw_pfn), .sw_valid(sw_valid), .sw_wen(sw_wen),
        .req_valid(req_valid), .req_ready(req_ready), .req_ifetch(req_ifetch),
        .req_write(req_write), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_fault_bank(rsp_fault_bank), .rsp_fault_page(rsp_fault_page)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(int bank, int page, int pfn, bit v, bit w);
        @(negedge clk);
        cfg_we = 1; cfg_bank = 1'(bank); cfg_page = 3'(page);
        cfg_pfn = 5'(pfn); cfg_valid = v; cfg_wen = w;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // issue one request at a negedge, sample the response one negedge later
    task automatic xlate(string rq, int bank, bit wr, int page, int off);
        int idx = bank * 8 + page;
        bit flt;
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1; req_ifetch = (bank == 0); req_write = wr;
        req_vaddr = 16'(page * 8192 + off);
        @(negedge clk);
        req_valid = 0;
        flt = !m_val[idx] || (bank == 1 && wr && !m_wen[idx]);
        if (flt) exp = {1'b1, 1'b1, 1'(bank), 3'(page), 18'd0};
        else     exp = {1'b1, 1'b0, 1'b0, 3'd0, 18'(int'(m_pfn[idx]) * 8192 + off)};
        check(rq, {8'd0, rsp_valid, rsp_fault, rsp_fault_bank, rsp_fault_page, rsp_paddr}, exp);
    endtask

    task automatic sweep(string rq);
        for (int b = 0; b < 2; b++)
            for (int p = 0; p < 8; p++)
                for (int w = 0; w < 2; w++) begin
                    xlate(rq, b, 1'(w), p, 0);
                    xlate(rq, b, 1'(w), p, 8191);
                    xlate(rq, b, 1'(w), p, (p * 1237 + b * 77) % 8192);
                end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_pfn[i] = 0; m_val[i] = 0; m_wen[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
        check("R1 sw_busy", {31'd0, sw_busy}, 0);
        check("R1 req_ready", {31'd0, req_ready}, 1);
        xlate("R1 insn invalid after reset", 0, 0, 4, 100);
        xlate("R1 data invalid after reset", 1, 1, 7, 5);

        // R6: program both banks with distinct patterns
        for (int p = 0; p < 8; p++) begin
            m_pfn[p] = 5'((p * 3 + 1) % 32); m_val[p] = (p != 5); m_wen[p] = 0;
            cfg_write(0, p, m_pfn[p], m_val[p], m_wen[p]);
            m_pfn[8+p] = 5'((p * 5 + 2) % 32); m_val[8+p] = (p != 2); m_wen[8+p] = p[0];
            cfg_write(1, p, m_pfn[8+p], m_val[8+p], m_wen[8+p]);
        end
        // R2 R3 R4 R5: full sweep of banks, pages, read/write, offsets
        sweep("R2/R3/R4/R5 sweep A");

        // R6: single entry rewrite affects only that entry
        m_pfn[8+3] = 5'd31; m_val[8+3] = 1; m_wen[8+3] = 0;
        cfg_write(1, 3, 31, 1, 0);
        xlate("R6 rewritten entry", 1, 0, 3, 42);
        xlate("R6 rewritten entry read-only", 1, 1, 3, 42);
        xlate("R6 other bank same page", 0, 0, 3, 42);
        xlate("R6 neighbour page", 1, 0, 4, 42);

        // R7 R8 R9: context swap
        @(negedge clk);
        sw_start = 1;
        @(negedge clk);
        sw_start = 0;
        begin
            int n = 0;
            while (sw_busy && n < 40) begin
                check("R7 swap index order", {28'd0, sw_idx}, 32'(n));
                if (n == 5) begin
                    req_valid = 1; req_ifetch = 0; req_vaddr = 16'h2000;
                    check("R8 req_ready low", {31'd0, req_ready}, 0);
                end
                if (n == 6) begin
                    req_valid = 0;
                    check("R8 no response in swap", {31'd0, rsp_valid}, 0);
                end
                if (n == 8) sw_start = 1;
                if (n == 9) sw_start = 0;
                if (n == 10) begin
                    cfg_we = 1; cfg_bank = 0; cfg_page = 3'd2; cfg_pfn = 5'd0;
                    cfg_valid = 0; cfg_wen = 0;
                end
                if (n == 11) cfg_we = 0;
                @(negedge clk);
                n++;
            end
            check("R7 swap length", 32'(n), 16);
            check("R9 no restart", {31'd0, sw_busy}, 0);
        end
        for (int i = 0; i < 16; i++) begin
            m_pfn[i] = 5'((i * 7 + 3) % 32); m_val[i] = (i != 9); m_wen[i] = (i != 12);
        end
        check("R8 ready after swap", {31'd0, req_ready}, 1);
        xlate("R9 cfg write ignored in swap", 0, 0, 2, 77);
        sweep("R7/R3/R5 sweep B");
        xlate("R5 ifetch ignores write", 0, 1, 4, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule